// File: doc/BRIEF.md
# Endpoint Bank Handshake Controller

This block keeps the firmware-side view of a multi-bank packet buffer for a single device endpoint. It counts how many banks hold data that is still waiting, tracks the bank that firmware should work on next, and raises a FIFO-control bit whenever that bank is handed to firmware. On an IN endpoint the handed-over bank is empty and ready to be filled. On an OUT endpoint it is full and ready to be read. The same firmware release strobe therefore means "send this bank" on IN and "free this bank" on OUT.

On IN endpoints firmware can also withdraw the bank it committed most recently. The kill takes one cycle. If an IN token is served in that same cycle and only one bank is busy, the bank goes out on the bus instead of being discarded. If two or more banks are busy, the oldest one is sent and the newest one is discarded. Three status sources can raise an interrupt line, and each has its own enable.

The controller is a four-state machine. In OFF the endpoint is a control endpoint or unconfigured. In WAIT no bank is available to firmware. In OWN firmware holds the current bank. In KILL a kill is being resolved. The transitions are:
- ENABLE (OFF to WAIT) when the kind is IN or OUT.
- DISABLE (any state to OFF) when the kind becomes control.
- GRANT (WAIT to OWN) when IN has a free bank or OUT has a full one.
- HANDOFF (OWN to WAIT) on the release strobe.
- KILL (WAIT or OWN to KILL) on a kill request for an IN endpoint.
- DONE (KILL to OWN) one cycle later.

Top module: `ep_bank_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are 0.
- R2: With `ep_kind` 00 or 11 (control), `fifo_ctl`, `tx_ready` and `rx_ready` stay 0, `busy_cnt` and `cur_bank` are cleared to 0, and `fifo_clr` has no effect.
- R3: With `ep_kind` 01 (IN), `fifo_ctl` and `tx_ready` rise together in the cycle after a waiting cycle in which `busy_cnt` is below NUM_BANKS. `rx_ready` stays 0.
- R4: On IN, `fifo_clr` while `fifo_ctl` is high increments `busy_cnt`, advances `cur_bank` modulo NUM_BANKS and drops `fifo_ctl` for at least one cycle. `fifo_clr` while `fifo_ctl` is low is ignored.
- R5: With `ep_kind` 10 (OUT), `out_rx` increments `busy_cnt` while it is below NUM_BANKS and is dropped otherwise. `fifo_ctl` and `rx_ready` rise together in the cycle after a waiting cycle with `busy_cnt` nonzero.
- R6: On OUT, `fifo_clr` while `fifo_ctl` is high decrements `busy_cnt` and advances `cur_bank` modulo NUM_BANKS. An `out_rx` in the same cycle is counted too.
- R7: On IN, `in_token` decrements a nonzero `busy_cnt` and leaves a zero count unchanged.
- R8: On IN, `kill_req` outside a kill raises `kill_busy` for exactly one cycle. If no token arrives in that cycle and `busy_cnt` is nonzero, the count drops by one and `cur_bank` steps back one bank. `fifo_ctl` is high afterwards.
- R9: If an IN token arrives during the kill cycle with `busy_cnt` equal to 1, the bank is sent instead: the count drops by one, `cur_bank` is unchanged, and `fifo_ctl`/`tx_ready` are set.
- R10: If an IN token arrives during the kill cycle with `busy_cnt` of 2 or more, the count drops by two and `cur_bank` steps back one bank.
- R11: A kill with `busy_cnt` 0 completes with the count unchanged. `kill_req` during a kill is ignored. `kill_req` on OUT or control endpoints is ignored.
- R12: `ie_set`/`ie_clr` bits set and clear three enables. Bit 0 gates `tx_ready`, bit 1 gates `rx_ready`, and bit 2 gates a nonzero `busy_cnt`. Clear wins when both strobes are given. `irq` is the OR of the enabled sources.
- R13: `busy_cnt` never exceeds NUM_BANKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_kind | input | 2 | Endpoint kind: 00 control, 01 IN, 10 OUT, 11 treated as control |
| fifo_clr | input | 1 | Firmware release strobe for the current bank |
| kill_req | input | 1 | Firmware request to withdraw the last committed IN bank |
| ie_set | input | 3 | Interrupt enable set strobes |
| ie_clr | input | 3 | Interrupt enable clear strobes |
| in_token | input | 1 | Bus served an IN token |
| out_rx | input | 1 | Bus received an OUT packet |
| fifo_ctl | output | 1 | Current bank is handed to firmware |
| tx_ready | output | 1 | IN bank free for firmware to fill |
| rx_ready | output | 1 | OUT bank full for firmware to read |
| kill_busy | output | 1 | Kill in progress |
| busy_cnt | output | CNT_W (2) | Number of busy banks |
| cur_bank | output | PTR_W (2) | Index of the bank firmware works on |
| irq | output | 1 | Interrupt request |

## Verification
A wrong machine state shows at `fifo_ctl` and `kill_busy` in the cycle right after the edge that entered it. A wrong count or pointer shows on `busy_cnt` and `cur_bank` after the same edge. Every step of the stimulus is therefore compared on all outputs one edge after its inputs. The kill race cases are the most sensitive ones. A count that drops by the wrong amount, or a pointer that steps back when the bank was actually sent, shows in the first compare after the kill cycle. A stuck enable or a wrong source mapping flips `irq` in the same compare.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_IN   = 2'b01,
        EP_OUT  = 2'b10,
        EP_RSVD = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2,
        ST_KILL = 2'd3
    } bank_state_e;

    localparam int IRQ_SRC = 3;

endpackage

// File: rtl/ep_bank_fsm.sv
module ep_bank_fsm
    import ep_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_in,
    input  logic is_out,
    input  logic fw_clr,
    input  logic kill_req,
    input  logic room,
    input  logic has_data,
    output logic own,
    output logic kill_active
);

    bank_state_e state_q, state_d;
    logic        enabled;

    assign enabled = is_in | is_out;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions: ENABLE, DISABLE, GRANT, HANDOFF, KILL, DONE
    always_comb begin
        state_d = state_q;
        if (!enabled) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_WAIT;
                ST_WAIT: begin
                    if (is_in && kill_req)     state_d = ST_KILL;
                    else if (is_in && room)    state_d = ST_OWN;
                    else if (is_out && has_data) state_d = ST_OWN;
                end
                ST_OWN: begin
                    if (is_in && kill_req)     state_d = ST_KILL;
                    else if (fw_clr)           state_d = ST_WAIT;
                end
                ST_KILL: state_d = ST_OWN;
            endcase
        end
    end

    // outputs
    always_comb begin
        own         = 1'b0;
        kill_active = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_WAIT: ;
            ST_OWN:  own = 1'b1;
            ST_KILL: kill_active = 1'b1;
        endcase
    end

endmodule

// File: rtl/ep_bank_count.sv
module ep_bank_count #(
    parameter int NUM_BANKS = 3,
    parameter int CNT_W     = 2,
    parameter int PTR_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic             unpush,
    output logic [CNT_W-1:0] cnt,
    output logic [PTR_W-1:0] fill_ptr,
    output logic [PTR_W-1:0] drain_ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BANKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] fill_q, drain_q;

    function automatic logic [PTR_W-1:0] fwd(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] back(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            fill_q  <= '0;
            drain_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop) - CNT_W'(unpush);
            if (push)        fill_q <= fwd(fill_q);
            else if (unpush) fill_q <= back(fill_q);
            if (pop)         drain_q <= fwd(drain_q);
        end
    end

    assign cnt       = cnt_q;
    assign fill_ptr  = fill_q;
    assign drain_ptr = drain_q;

endmodule

// File: rtl/ep_irq_mask.sv
module ep_irq_mask #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_en,
    input  logic [NSRC-1:0] clr_en,
    input  logic [NSRC-1:0] src,
    output logic            irq
);

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n)         en_q[i] <= 1'b0;
            else if (clr_en[i]) en_q[i] <= 1'b0;
            else if (set_en[i]) en_q[i] <= 1'b1;
        end
        assign hit[i] = en_q[i] & src[i];
    end

    assign irq = |hit;

endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
    import ep_bank_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int CNT_W = $clog2(NUM_BANKS + 1),
    localparam int PTR_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         ep_kind,
    input  logic               fifo_clr,
    input  logic               kill_req,
    input  logic [IRQ_SRC-1:0] ie_set,
    input  logic [IRQ_SRC-1:0] ie_clr,
    input  logic               in_token,
    input  logic               out_rx,
    output logic               fifo_ctl,
    output logic               tx_ready,
    output logic               rx_ready,
    output logic               kill_busy,
    output logic [CNT_W-1:0]   busy_cnt,
    output logic [PTR_W-1:0]   cur_bank,
    output logic               irq
);

    logic is_in, is_out;
    logic room, has_data, one_left;
    logic own, kill_active;
    logic push, pop, unpush;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] fill_ptr, drain_ptr;

    assign is_in    = (ep_kind == EP_IN);
    assign is_out   = (ep_kind == EP_OUT);
    assign room     = (cnt < CNT_W'(NUM_BANKS));
    assign has_data = (cnt != '0);
    assign one_left = (cnt == CNT_W'(1));

    ep_bank_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_in       (is_in),
        .is_out      (is_out),
        .fw_clr      (fifo_clr),
        .kill_req    (kill_req),
        .room        (room),
        .has_data    (has_data),
        .own         (own),
        .kill_active (kill_active)
    );

    // IN: firmware fills, bus drains. OUT: bus fills, firmware drains.
    always_comb begin
        push   = 1'b0;
        pop    = 1'b0;
        unpush = 1'b0;
        if (is_in) begin
            push   = own & fifo_clr & ~kill_req;
            pop    = in_token & has_data;
            unpush = kill_active & has_data & ~(in_token & one_left);
        end else if (is_out) begin
            push   = out_rx & room;
            pop    = own & fifo_clr;
        end
    end

    ep_bank_count #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W),
        .PTR_W     (PTR_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (~(is_in | is_out)),
        .push      (push),
        .pop       (pop),
        .unpush    (unpush),
        .cnt       (cnt),
        .fill_ptr  (fill_ptr),
        .drain_ptr (drain_ptr)
    );

    assign fifo_ctl  = own;
    assign tx_ready  = own & is_in;
    assign rx_ready  = own & is_out;
    assign kill_busy = kill_active;
    assign busy_cnt  = cnt;
    assign cur_bank  = is_in ? fill_ptr : drain_ptr;

    ep_irq_mask #(
        .NSRC (IRQ_SRC)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (ie_set),
        .clr_en (ie_clr),
        .src    ({has_data, rx_ready, tx_ready}),
        .irq    (irq)
    );

endmodule

// File: rtl/ep_bank_ctrl_chk.sv
module ep_bank_ctrl_chk
    import ep_bank_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ep_kind,
    input logic             fifo_clr,
    input logic             kill_req,
    input logic             fifo_ctl,
    input logic             tx_ready,
    input logic             rx_ready,
    input logic             kill_busy,
    input logic [CNT_W-1:0] busy_cnt,
    input logic             irq
);

    p_ctrl_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_kind == EP_CTRL || ep_kind == EP_RSVD) |=> (!fifo_ctl && busy_cnt == '0));

    p_dir_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && rx_ready));

    p_release_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ctl && fifo_clr) |=> !fifo_ctl);

    p_kill_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_busy |=> !kill_busy);

    p_kill_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kill_busy) |-> $past(ep_kind == EP_IN && kill_req));

    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_ready || rx_ready || busy_cnt != '0));

    p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(NUM_BANKS));

endmodule

bind ep_bank_ctrl ep_bank_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ep_kind   (ep_kind),
    .fifo_clr  (fifo_clr),
    .kill_req  (kill_req),
    .fifo_ctl  (fifo_ctl),
    .tx_ready  (tx_ready),
    .rx_ready  (rx_ready),
    .kill_busy (kill_busy),
    .busy_cnt  (busy_cnt),
    .irq       (irq)
);

// File: tb/tb_ep_bank_ctrl.sv
`timescale 1ns/1ps
module tb_ep_bank_ctrl;
    import ep_bank_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] kind = EP_IN;
    logic       fifo_clr = 1'b0, kill_req = 1'b0, in_token = 1'b0, out_rx = 1'b0;
    logic [2:0] ie_set = '0, ie_clr = '0;
    logic       fifo_ctl, tx_ready, rx_ready, kill_busy, irq;
    logic [1:0] busy_cnt, cur_bank;

    int cycn = 0;
    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int         due;
        logic [8:0] v;
        string      r;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cycn <= cycn + 1;

    ep_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ep_kind(kind), .fifo_clr(fifo_clr),
        .kill_req(kill_req), .ie_set(ie_set), .ie_clr(ie_clr),
        .in_token(in_token), .out_rx(out_rx), .fifo_ctl(fifo_ctl),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .kill_busy(kill_busy),
        .busy_cnt(busy_cnt), .cur_bank(cur_bank), .irq(irq)
    );

    function automatic logic [8:0] act();
        return {busy_cnt, cur_bank, fifo_ctl, tx_ready, rx_ready, kill_busy, irq};
    endfunction

    // monitor: pops expected items as their cycle comes up
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due == cycn) begin
            n_cmp++;
            if (act() !== sb[0].v) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual cnt,cur,fc,tx,rx,kb,irq=%b expected %b",
                         sb[0].r, cycn, act(), sb[0].v);
            end
            void'(sb.pop_front());
        end
    end

    // driver: called at a negedge with strobes already applied
    task automatic step(input logic [1:0] c, input logic [1:0] cu, input logic f,
                        input logic k, input logic q, input string r);
        exp_t e;
        e.due = cycn + 1;
        e.v   = {c, cu, f, f & (kind == EP_IN), f & (kind == EP_OUT), k, q};
        e.r   = r;
        sb.push_back(e);
        @(negedge clk);
        fifo_clr = 0; kill_req = 0; in_token = 0; out_rx = 0;
        ie_set = '0; ie_clr = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;
        if (act() !== 9'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %b expected %b", act(), 9'b0);
        end
        rst_n = 1'b1;
        // IN endpoint, 3 banks
        step(0,0,0,0,0,"R1");
        step(0,0,1,0,0,"R3");
        ie_set = 3'b001;   step(0,0,1,0,1,"R12");
        fifo_clr = 1;      step(1,1,0,0,0,"R4");
        step(1,1,1,0,1,"R3");
        fifo_clr = 1;      step(2,2,0,0,0,"R4");
        step(2,2,1,0,1,"R3");
        fifo_clr = 1;      step(3,0,0,0,0,"R4");
        step(3,0,0,0,0,"R13");
        fifo_clr = 1;      step(3,0,0,0,0,"R4");
        in_token = 1;      step(2,0,0,0,0,"R7");
        step(2,0,1,0,1,"R3");
        kill_req = 1;      step(2,0,0,1,0,"R8");
        in_token = 1;      step(0,2,1,0,1,"R10");
        kill_req = 1;      step(0,2,0,1,0,"R11");
        kill_req = 1;      step(0,2,1,0,1,"R11");
        step(0,2,1,0,1,"R11");
        fifo_clr = 1;      step(1,0,0,0,0,"R4");
        kill_req = 1;      step(1,0,0,1,0,"R8");
        in_token = 1;      step(0,0,1,0,1,"R9");
        fifo_clr = 1;      step(1,1,0,0,0,"R4");
        kill_req = 1;      step(1,1,0,1,0,"R8");
        step(0,0,1,0,1,"R8");
        in_token = 1;      step(0,0,1,0,1,"R7");
        ie_set = 3'b100;   step(0,0,1,0,1,"R12");
        ie_clr = 3'b001;   step(0,0,1,0,0,"R12");
        fifo_clr = 1;      step(1,1,0,0,1,"R12");
        ie_set = 3'b100; ie_clr = 3'b100; step(1,1,1,0,0,"R12");
        // control endpoint
        kind = EP_CTRL; fifo_clr = 1; step(0,0,0,0,0,"R2");
        fifo_clr = 1;      step(0,0,0,0,0,"R2");
        // OUT endpoint
        kind = EP_OUT;     step(0,0,0,0,0,"R5");
        out_rx = 1;        step(1,0,0,0,0,"R5");
        step(1,0,1,0,0,"R5");
        ie_set = 3'b010;   step(1,0,1,0,1,"R12");
        out_rx = 1;        step(2,0,1,0,1,"R5");
        out_rx = 1;        step(3,0,1,0,1,"R5");
        out_rx = 1;        step(3,0,1,0,1,"R5");
        fifo_clr = 1;      step(2,1,0,0,0,"R6");
        step(2,1,1,0,1,"R5");
        kill_req = 1;      step(2,1,1,0,1,"R11");
        fifo_clr = 1; out_rx = 1; step(2,2,0,0,0,"R6");
        step(2,2,1,0,1,"R5");
        fifo_clr = 1;      step(1,0,0,0,0,"R6");
        step(1,0,1,0,1,"R5");
        fifo_clr = 1;      step(0,1,0,0,0,"R6");
        step(0,1,0,0,0,"R5");
        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule